// File: doc/BRIEF.md
# Zoned External Bus Controller

This block sits between an internal processor bus and an external asynchronous memory and peripheral bus. Every internal request is decoded into one of five address zones, and the controller runs one external access cycle with that zone's chip select held low. The five zones drive only three chip-select lines: zones 0 and 1 share one line, zone 2 has a line of its own, and zones 6 and 7 share the third line.

Each zone has its own configuration: a 5-bit wait-state count, and a flag that decides whether the external ready input may stretch the access. A mode pin sampled during reset decides whether the boot region is served by zone 7 or left unmapped. The internal side uses a one-cycle request pulse and a one-cycle acknowledge pulse, and read data comes back together with the acknowledge. An address outside every zone gets an immediate error acknowledge.

Top module: `ext_bus_zones`

## Requirements
- R1: After reset every zone has wait count 31 with ready ignored, so a mapped access acknowledges 34 cycles after it is accepted. All chip selects are high and `ack`/`err` are low while idle after reset.
- R2: The zone is chosen from the top four address bits: 0x0 selects zone 0, 0x1 zone 1, 0x2 and 0x3 zone 2, 0x6 zone 6, and 0x7 zone 7. The chip-select lines are active low, with `ext_cs_n[0]` for zones 0/1, `ext_cs_n[1]` for zone 2 and `ext_cs_n[2]` for zones 6/7. At most one line is low at any time.
- R3: A mapped access has one lead cycle with the chip select low and both strobes high. It then has 1 + wait-count active cycles with a strobe low, and one trail cycle in which `ack` is high. `ack` is therefore seen wait-count + 3 cycles after the accepting clock edge.
- R4: When a zone's ready flag is set, the active phase keeps going after the wait count has run out, until a cycle in which `ext_ready` is high.
- R5: When a zone's ready flag is clear, `ext_ready` has no effect on the access length.
- R6: `boot_mode` is captured while `rst` is high. If it was high, the top-nibble 0xF region is routed to zone 7 (`ext_cs_n[2]`) using zone 7's settings. If it was low, that region is unmapped.
- R7: A request to an unmapped address is acknowledged one cycle after acceptance with `err` high and `rdata` zero. No chip select goes low for it.
- R8: A read returns the `ext_rdata` value sampled in the last active cycle, presented with `ack`; `ext_oe_n` is low only during the active phase of a read. A write drives `req_wdata` onto `ext_wdata` with `ext_we_n` low during the active phase, and its `rdata` is zero.
- R9: A configuration write with `cfg_we` high stores `cfg_wdata[4:0]` as the wait count and `cfg_wdata[5]` as the ready flag. Selectors 0 to 4 map to zones 0, 1, 2, 6 and 7. Selector values 5 to 7 change nothing.
- R10: A request made while an access is in progress is ignored and never acknowledged. All chip selects are high for at least one cycle after each acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 1 | Boot mapping pin, captured during reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Zone selector for configuration |
| cfg_wdata | input | 6 | {ready flag, wait count} |
| req | input | 1 | One-cycle request pulse |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Internal word address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle acknowledge |
| err | output | 1 | Unmapped-address flag, valid with ack |
| rdata | output | 16 | Read data, valid with ack |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_ready | input | 1 | External ready |
| ext_cs_n | output | 3 | Active-low chip selects |
| ext_oe_n | output | 1 | Active-low read strobe |
| ext_we_n | output | 1 | Active-low write strobe |

## Verification
On every cycle the embedded assertions check the following:
- at most one chip select is low;
- a strobe is low only while a chip select is low;
- `ack` lasts a single cycle;
- an error acknowledge carries zero data and no select;
- the selects release after every acknowledge;
- an expired count with ready flagged and `ext_ready` low holds the active phase;
- an invalid configuration selector leaves the table untouched;
- the captured boot mode never changes outside reset.

Only the bench's scenarios can show the rest: the exact cycle counts per wait setting, the address-to-line mapping, the boot remap under both pin levels, the data paths, and that a request made while busy is dropped.

// File: rtl/ebz_pkg.sv
package ebz_pkg;
   localparam int NZONE = 5;
   localparam int NLINE = 3;

   typedef enum logic [2:0] {
      ZN_0 = 3'd0,
      ZN_1 = 3'd1,
      ZN_2 = 3'd2,
      ZN_6 = 3'd3,
      ZN_7 = 3'd4
   } zone_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_ACT,
      ST_TRAIL,
      ST_MISS
   } seq_st_e;

   function automatic logic [1:0] line_of(input logic [2:0] z);
      case (z)
         ZN_0, ZN_1: line_of = 2'd0;
         ZN_2:       line_of = 2'd1;
         default:    line_of = 2'd2;
      endcase
   endfunction
endpackage

// File: rtl/ebz_cfg_bank.sv
module ebz_cfg_bank
   import ebz_pkg::*;
#(
   parameter int WS_W = 5
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        we,
   input  logic [2:0]                  sel,
   input  logic [WS_W:0]               wdata,
   output logic [NZONE-1:0][WS_W-1:0]  ws_tab,
   output logic [NZONE-1:0]            rdy_tab
);
   for (genvar z = 0; z < NZONE; z++) begin : g_zone
      always_ff @(posedge clk) begin
         if (rst) begin
            ws_tab[z]  <= '1;
            rdy_tab[z] <= 1'b0;
         end else if (we && (sel == 3'(z))) begin
            ws_tab[z]  <= wdata[WS_W-1:0];
            rdy_tab[z] <= wdata[WS_W];
         end
      end
   end

   a_r9_bad_sel_ignored: assert property (@(posedge clk) disable iff (rst)
      (we && (sel >= 3'(NZONE))) |=> ($stable(ws_tab) && $stable(rdy_tab)));
endmodule

// File: rtl/ebz_decode.sv
module ebz_decode
   import ebz_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter bit BOOT_REMAP  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              boot_sel,
   output logic              hit,
   output logic [2:0]        zone
);
   localparam int RGN_LSB = ADDR_W - 4;

   logic [3:0] region;
   logic       boot_hit;

   assign region = addr[ADDR_W-1:RGN_LSB];

   if (BOOT_REMAP) begin : g_remap
      assign boot_hit = boot_sel;
   end else begin : g_noremap
      assign boot_hit = 1'b0;
   end

   always_comb begin
      hit  = 1'b1;
      zone = ZN_0;
      case (region)
         4'h0:       zone = ZN_0;
         4'h1:       zone = ZN_1;
         4'h2, 4'h3: zone = ZN_2;
         4'h6:       zone = ZN_6;
         4'h7:       zone = ZN_7;
         4'hF: begin
            zone = ZN_7;
            hit  = boot_hit;
         end
         default:    hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/ebz_seq.sv
module ebz_seq
   import ebz_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int WS_W   = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               req,
   input  logic               req_we,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic               hit,
   input  logic [2:0]         zone,
   input  logic [WS_W-1:0]    zone_ws,
   input  logic               zone_rdy,
   input  logic               ext_ready,
   input  logic [DATA_W-1:0]  ext_rdata,
   output logic [2:0]         zone_q,
   output logic               ack,
   output logic               err,
   output logic [DATA_W-1:0]  rdata,
   output logic [ADDR_W-1:0]  ext_addr,
   output logic [DATA_W-1:0]  ext_wdata,
   output logic [NLINE-1:0]   cs_n,
   output logic               oe_n,
   output logic               we_n
);
   seq_st_e            st;
   logic [WS_W-1:0]    cnt;
   logic               rdy_q;
   logic               we_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  wd_q;
   logic [DATA_W-1:0]  rd_q;
   logic               busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         rdy_q  <= 1'b0;
         we_q   <= 1'b0;
         zone_q <= ZN_0;
         addr_q <= '0;
         wd_q   <= '0;
         rd_q   <= '0;
      end else begin
         case (st)
            ST_IDLE: if (req) begin
               addr_q <= req_addr;
               wd_q   <= req_wdata;
               we_q   <= req_we;
               zone_q <= zone;
               st     <= hit ? ST_LEAD : ST_MISS;
            end
            ST_LEAD: begin
               cnt   <= zone_ws;
               rdy_q <= zone_rdy;
               st    <= ST_ACT;
            end
            ST_ACT: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else if (!rdy_q || ext_ready) begin
                  rd_q <= we_q ? '0 : ext_rdata;
                  st   <= ST_TRAIL;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st == ST_LEAD) || (st == ST_ACT) || (st == ST_TRAIL);
   assign ack       = (st == ST_TRAIL) || (st == ST_MISS);
   assign err       = (st == ST_MISS);
   assign rdata     = (st == ST_TRAIL) ? rd_q : '0;
   assign oe_n      = !((st == ST_ACT) && !we_q);
   assign we_n      = !((st == ST_ACT) && we_q);
   assign ext_addr  = addr_q;
   assign ext_wdata = wd_q;

   for (genvar l = 0; l < NLINE; l++) begin : g_cs
      assign cs_n[l] = !(busy && (line_of(zone_q) == 2'(l)));
   end

   a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
      $countones(~cs_n) <= 1);
   a_r8_strobe_in_select: assert property (@(posedge clk) disable iff (rst)
      (!oe_n || !we_n) |-> !(&cs_n));
   a_r3_ack_pulse: assert property (@(posedge clk) disable iff (rst)
      ack |=> !ack);
   a_r7_err_clean: assert property (@(posedge clk) disable iff (rst)
      err |-> (ack && (rdata == '0) && (&cs_n)));
   a_r10_select_gap: assert property (@(posedge clk) disable iff (rst)
      (ack && !err) |=> (&cs_n));
   a_r4_ready_hold: assert property (@(posedge clk) disable iff (rst)
      ((st == ST_ACT) && (cnt == '0) && rdy_q && !ext_ready) |=> (st == ST_ACT));
endmodule

// File: rtl/ext_bus_zones.sv
module ext_bus_zones
   import ebz_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int WS_W       = 5,
   parameter bit BOOT_REMAP = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               boot_mode,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_sel,
   input  logic [WS_W:0]      cfg_wdata,
   input  logic               req,
   input  logic               req_we,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               ack,
   output logic               err,
   output logic [DATA_W-1:0]  rdata,
   output logic [ADDR_W-1:0]  ext_addr,
   output logic [DATA_W-1:0]  ext_wdata,
   input  logic [DATA_W-1:0]  ext_rdata,
   input  logic               ext_ready,
   output logic [NLINE-1:0]   ext_cs_n,
   output logic               ext_oe_n,
   output logic               ext_we_n
);
   if (ADDR_W < 8) begin : g_chk_addr
      $error("ext_bus_zones: ADDR_W must be at least 8");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("ext_bus_zones: DATA_W must be positive");
   end
   if ((WS_W < 1) || (WS_W > 8)) begin : g_chk_ws
      $error("ext_bus_zones: WS_W must lie in 1..8");
   end

   logic                        boot_q;
   logic [NZONE-1:0][WS_W-1:0]  ws_tab;
   logic [NZONE-1:0]            rdy_tab;
   logic                        hit;
   logic [2:0]                  zone;
   logic [2:0]                  zone_q;
   logic [WS_W-1:0]             sel_ws;
   logic                        sel_rdy;

   always_ff @(posedge clk) begin
      if (rst) boot_q <= boot_mode;
   end

   ebz_cfg_bank #(.WS_W(WS_W)) u_cfg (
      .clk     (clk),
      .rst     (rst),
      .we      (cfg_we),
      .sel     (cfg_sel),
      .wdata   (cfg_wdata),
      .ws_tab  (ws_tab),
      .rdy_tab (rdy_tab)
   );

   ebz_decode #(.ADDR_W(ADDR_W), .BOOT_REMAP(BOOT_REMAP)) u_dec (
      .addr     (req_addr),
      .boot_sel (boot_q),
      .hit      (hit),
      .zone     (zone)
   );

   always_comb begin
      sel_ws  = '1;
      sel_rdy = 1'b0;
      for (int z = 0; z < NZONE; z++) begin
         if (zone_q == 3'(z)) begin
            sel_ws  = ws_tab[z];
            sel_rdy = rdy_tab[z];
         end
      end
   end

   ebz_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .req       (req),
      .req_we    (req_we),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .hit       (hit),
      .zone      (zone),
      .zone_ws   (sel_ws),
      .zone_rdy  (sel_rdy),
      .ext_ready (ext_ready),
      .ext_rdata (ext_rdata),
      .zone_q    (zone_q),
      .ack       (ack),
      .err       (err),
      .rdata     (rdata),
      .ext_addr  (ext_addr),
      .ext_wdata (ext_wdata),
      .cs_n      (ext_cs_n),
      .oe_n      (ext_oe_n),
      .we_n      (ext_we_n)
   );

   a_r6_mode_held: assert property (@(posedge clk) disable iff (rst)
      !rst |=> $stable(boot_q));
   a_r6_boot_needs_mode: assert property (@(posedge clk) disable iff (rst)
      (hit && (req_addr[ADDR_W-1 -: 4] == 4'hF)) |-> boot_q);
endmodule

// File: tb/ext_bus_zones_test.sv
module ext_bus_zones_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] RD_MASK = 16'h5A3C;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        boot_mode = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [5:0]  cfg_wdata = '0;
   logic        req = 1'b0;
   logic        req_we = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        ack, err;
   logic [15:0] rdata, ext_addr, ext_wdata, ext_rdata;
   logic        ext_ready;
   logic [2:0]  ext_cs_n;
   logic        ext_oe_n, ext_we_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_bus_zones uut (
      .clk(clk), .rst(rst), .boot_mode(boot_mode),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .ack(ack), .err(err), .rdata(rdata),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
      .ext_ready(ext_ready), .ext_cs_n(ext_cs_n),
      .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n)
   );

   // external device model
   int rdy_delay = 0;
   int strobe_cnt = 0;
   assign ext_rdata = ext_addr ^ RD_MASK;
   assign ext_ready = (strobe_cnt >= rdy_delay);
   always @(posedge clk) strobe_cnt <= (!ext_oe_n || !ext_we_n) ? strobe_cnt + 1 : 0;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int failures = 0;

   typedef struct {
      int          lat;
      logic [15:0] rd;
      logic        er;
      logic [2:0]  csm;
      logic        is_wr;
      logic [15:0] wd;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          issue_cyc = 0;
   logic [2:0]  cs_seen = '0;
   logic        oe_seen = 1'b0;
   logic [15:0] wd_seen = '0;
   int          stray = 0;
   logic        post_ack = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // monitor: pops expected items as the design acknowledges
   always @(negedge clk) begin
      if (!rst) begin
         if (post_ack) begin
            check(&ext_cs_n, "R10", "cs_n after ack", ext_cs_n, 3'b111);
            post_ack = 1'b0;
         end
         cs_seen = cs_seen | ~ext_cs_n;
         if (!ext_oe_n) oe_seen = 1'b1;
         if (!ext_we_n) wd_seen = ext_wdata;
         check($countones(~ext_cs_n) <= 1, "R2", "select count", $countones(~ext_cs_n), 1);
         if (ack) begin
            if (sb.size() == 0) begin
               stray++;
            end else begin
               exp_t e;
               e = sb.pop_front();
               check((cyc - issue_cyc) == e.lat, e.tag, "latency", cyc - issue_cyc, e.lat);
               check(rdata == e.rd, e.tag, "rdata", rdata, e.rd);
               check(err == e.er, e.tag, "err", err, e.er);
               check(cs_seen == e.csm, e.tag, "select line", cs_seen, e.csm);
               if (e.is_wr) begin
                  check(wd_seen == e.wd, e.tag, "write data", wd_seen, e.wd);
                  check(!oe_seen, e.tag, "oe_n during write", oe_seen, 0);
               end
               if (!e.er) post_ack = 1'b1;
            end
         end
      end
   end

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst = 1'b1;
      boot_mode = mode;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      boot_mode = ~mode;
   endtask

   task automatic set_zone(input logic [2:0] sel, input logic rdy, input logic [4:0] ws);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_sel = sel;
      cfg_wdata = {rdy, ws};
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // driver: pushes the expected result, then raises a one-cycle request
   task automatic access(input logic [15:0] a, input logic w, input logic [15:0] wd,
                         input int lat, input logic er, input logic [2:0] csm,
                         input string tag);
      exp_t e;
      e.lat = lat;
      e.er = er;
      e.rd = (er || w) ? 16'h0 : (a ^ RD_MASK);
      e.csm = csm;
      e.is_wr = w;
      e.wd = wd;
      e.tag = tag;
      @(negedge clk);
      sb.push_back(e);
      cs_seen = '0;
      oe_seen = 1'b0;
      issue_cyc = cyc;
      req = 1'b1;
      req_we = w;
      req_addr = a;
      req_wdata = wd;
      @(negedge clk);
      req = 1'b0;
      wait (sb.size() == 0);
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset(1'b0);
      // R1: idle state after reset
      check(ext_cs_n == 3'b111, "R1", "cs_n idle", ext_cs_n, 3'b111);
      check(!ack && !err, "R1", "ack/err idle", {ack, err}, 0);
      // R1/R3: default 31 wait states -> 34
      access(16'h0123, 1'b0, '0, 34, 1'b0, 3'b001, "R1");
      // R2/R3: per-zone wait counts and line mapping
      set_zone(3'd0, 1'b0, 5'd0);
      access(16'h0456, 1'b0, '0, 3, 1'b0, 3'b001, "R3");
      set_zone(3'd1, 1'b0, 5'd2);
      access(16'h1abc, 1'b0, '0, 5, 1'b0, 3'b001, "R2");
      set_zone(3'd2, 1'b0, 5'd5);
      access(16'h2abc, 1'b0, '0, 8, 1'b0, 3'b010, "R2");
      access(16'h3010, 1'b0, '0, 8, 1'b0, 3'b010, "R2");
      set_zone(3'd3, 1'b0, 5'd1);
      // R8: write path
      access(16'h6044, 1'b1, 16'hBEEF, 4, 1'b0, 3'b100, "R8");
      set_zone(3'd4, 1'b0, 5'd4);
      access(16'h7f00, 1'b0, '0, 7, 1'b0, 3'b100, "R8");
      // R4: ready stretches beyond the wait count
      set_zone(3'd2, 1'b1, 5'd1);
      rdy_delay = 6;
      access(16'h2200, 1'b0, '0, 9, 1'b0, 3'b010, "R4");
      rdy_delay = 0;
      access(16'h2201, 1'b0, '0, 4, 1'b0, 3'b010, "R4");
      // R5: ready ignored when the flag is clear
      rdy_delay = 20;
      access(16'h6100, 1'b0, '0, 4, 1'b0, 3'b100, "R5");
      rdy_delay = 0;
      // R7 / R6 (mode low): unmapped addresses
      access(16'h4000, 1'b0, '0, 1, 1'b1, 3'b000, "R7");
      access(16'hF123, 1'b0, '0, 1, 1'b1, 3'b000, "R6");
      // R9: selector 5 changes nothing (zone 7 still 4 waits)
      set_zone(3'd5, 1'b0, 5'd0);
      set_zone(3'd7, 1'b1, 5'd0);
      access(16'h7001, 1'b0, '0, 7, 1'b0, 3'b100, "R9");
      // R10: request during a busy access is dropped
      begin
         exp_t e;
         e.lat = 8; e.er = 1'b0; e.rd = 16'h2300 ^ RD_MASK; e.csm = 3'b010;
         e.is_wr = 1'b0; e.wd = '0; e.tag = "R10";
         set_zone(3'd2, 1'b0, 5'd5);
         @(negedge clk);
         sb.push_back(e);
         cs_seen = '0;
         issue_cyc = cyc;
         req = 1'b1; req_we = 1'b0; req_addr = 16'h2300;
         @(negedge clk);
         req = 1'b0;
         repeat (2) @(negedge clk);
         req = 1'b1; req_addr = 16'h0777;
         @(negedge clk);
         req = 1'b0;
         wait (sb.size() == 0);
         repeat (12) @(negedge clk);
         check(stray == 0, "R10", "stray acks", stray, 0);
      end
      // R6: mode high routes boot region to zone 7
      do_reset(1'b1);
      access(16'hF123, 1'b0, '0, 34, 1'b0, 3'b100, "R6");
      set_zone(3'd4, 1'b0, 5'd3);
      access(16'hF200, 1'b0, '0, 6, 1'b0, 3'b100, "R6");
      access(16'h7200, 1'b0, '0, 6, 1'b0, 3'b100, "R6");
      access(16'h5000, 1'b0, '0, 1, 1'b1, 3'b000, "R7");
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule